// File: doc/BRIEF.md
# Three-Phase Accumulator Processor Core

This block is a small 8-bit processor core built around two data registers, A and B, and a 3-bit instruction register. Every instruction takes exactly three clock cycles. The first cycle captures an opcode. The second cycle decodes the opcode and loads A from the data input, or clears both registers. The third cycle writes the result of a four-function ALU back into B. B is always the left operand and is always the destination, so B behaves as the accumulator and A holds the fresh operand.

Instructions and operands arrive on plain input pins that are sampled in fixed phases. No handshake is used. The core never stalls, and a driver meets the timing by watching the phase output. That output also lets a checker line up its expected register values with each step of the sequence.

The opcodes 101, 110 and 111 are reserved. While one of them sits in the instruction register, the second and third phases change nothing. The phase sequence still runs, so the next instruction is fetched on schedule.

Top module: `acc_core`

## Requirements
- R1: A synchronous, active-high `rst` clears A, B and the instruction register, and sets `phase` to 1 at the next rising edge.
- R2: `phase` steps 1→2→3→1 on each rising edge outside reset and never shows 0.
- R3: The opcode on `instr_in` is captured only at the edge that ends phase 1; its value in phases 2 and 3 has no effect on A or B.
- R4: Opcode encodings are 000 ADD, 001 SUB, 010 AND, 011 OR and 100 CLR. At the edge ending phase 2, an ALU opcode (top bit 0) loads A from `data_in` and leaves B unchanged.
- R5: ADD writes (B + A) mod 256 into B at the edge ending phase 3.
- R6: SUB writes (B − A) mod 256 into B at the edge ending phase 3.
- R7: AND writes the bitwise B AND A into B at the edge ending phase 3.
- R8: OR writes the bitwise B OR A into B at the edge ending phase 3.
- R9: CLR zeroes both A and B at the edge ending phase 2, and phase 3 then leaves them unchanged.
- R10: With a reserved opcode (101, 110, 111) in the instruction register, A and B hold their values through phases 2 and 3.
- R11: `data_in` is ignored except at the edge ending phase 2 of an ALU opcode; A changes at no other edge except reset and CLR.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| instr_in | input | 3 | Opcode, sampled at the end of phase 1 |
| data_in | input | DATA_W (8) | Operand for A, sampled at the end of phase 2 |
| reg_a | output | DATA_W (8) | Contents of register A |
| reg_b | output | DATA_W (8) | Contents of register B (accumulator) |
| phase | output | 2 | Current phase: 1 fetch, 2 decode, 3 write-back |

## Verification
The bench builds the core with its default width of 8 bits. At that width the wrap of ADD past 255 and the borrow of SUB below zero can be forced in a single directed instruction each. A behavioural model predicts phase, A and B on every clock. Between directed corner cases and a long random program, every opcode is applied, including all three reserved codes. The random program also drives garbage on the unsampled inputs in every phase.

// File: rtl/acc_pkg.sv
package acc_pkg;
  localparam int OPC_W = 3;
  localparam int SEL_W = 2;

  typedef enum logic [1:0] {
    PH_FETCH  = 2'd1,
    PH_DECODE = 2'd2,
    PH_WRITE  = 2'd3
  } phase_t;

  localparam logic [OPC_W-1:0] OPC_ADD = 3'b000;
  localparam logic [OPC_W-1:0] OPC_SUB = 3'b001;
  localparam logic [OPC_W-1:0] OPC_AND = 3'b010;
  localparam logic [OPC_W-1:0] OPC_OR  = 3'b011;
  localparam logic [OPC_W-1:0] OPC_CLR = 3'b100;

  typedef enum logic [SEL_W-1:0] {
    SEL_ADD = 2'd0,
    SEL_SUB = 2'd1,
    SEL_AND = 2'd2,
    SEL_OR  = 2'd3
  } alu_sel_t;

  typedef struct packed {
    logic     alu_op;
    logic     clr;
    alu_sel_t sel;
  } ctl_t;
endpackage

// File: rtl/acc_phase_seq.sv
module acc_phase_seq
  import acc_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  output phase_t phase
);
  phase_t phase_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_FETCH;
    end else begin
      case (phase_q)
        PH_FETCH:  phase_q <= PH_DECODE;
        PH_DECODE: phase_q <= PH_WRITE;
        default:   phase_q <= PH_FETCH;
      endcase
    end
  end

  assign phase = phase_q;

  assert_phase_nonzero_R2: assert property (@(posedge clk) disable iff (rst)
    phase_q != 2'd0);
  assert_phase_wrap_R2: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_WRITE) |=> (phase_q == PH_FETCH));
endmodule

// File: rtl/acc_decode.sv
module acc_decode
  import acc_pkg::*;
(
  input  logic [OPC_W-1:0] opcode,
  output ctl_t             ctl
);
  always_comb begin
    ctl.alu_op = ~opcode[OPC_W-1];
    ctl.clr    = (opcode == OPC_CLR);
    ctl.sel    = alu_sel_t'(opcode[SEL_W-1:0]);
  end
endmodule

// File: rtl/acc_alu.sv
module acc_alu
  import acc_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] lhs,
  input  logic [W-1:0] rhs,
  input  alu_sel_t     sel,
  output logic [W-1:0] res
);
  logic [W-1:0] sum_w, diff_w, and_w, or_w;

  assign sum_w  = lhs + rhs;
  assign diff_w = lhs - rhs;

  for (genvar i = 0; i < W; i++) begin : g_lane
    assign and_w[i] = lhs[i] & rhs[i];
    assign or_w[i]  = lhs[i] | rhs[i];
  end

  always_comb begin
    case (sel)
      SEL_ADD: res = sum_w;
      SEL_SUB: res = diff_w;
      SEL_AND: res = and_w;
      default: res = or_w;
    endcase
  end
endmodule

// File: rtl/acc_core.sv
module acc_core
  import acc_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [2:0]        instr_in,
  input  logic [DATA_W-1:0] data_in,
  output logic [DATA_W-1:0] reg_a,
  output logic [DATA_W-1:0] reg_b,
  output logic [1:0]        phase
);
  phase_t            ph;
  logic [OPC_W-1:0]  ir_q;
  logic [DATA_W-1:0] a_q, b_q, alu_res;
  ctl_t              ctl;
  logic              is_reserved;

  acc_phase_seq u_seq (.clk(clk), .rst(rst), .phase(ph));
  acc_decode    u_dec (.opcode(ir_q), .ctl(ctl));
  acc_alu #(.W(DATA_W)) u_alu (.lhs(b_q), .rhs(a_q), .sel(ctl.sel), .res(alu_res));

  assign is_reserved = ~ctl.alu_op & ~ctl.clr;

  always_ff @(posedge clk) begin
    if (rst) begin
      ir_q <= '0;
      a_q  <= '0;
      b_q  <= '0;
    end else begin
      case (ph)
        PH_FETCH: ir_q <= instr_in;
        PH_DECODE: begin
          if (ctl.clr) begin
            a_q <= '0;
            b_q <= '0;
          end else if (ctl.alu_op) begin
            a_q <= data_in;
          end
        end
        PH_WRITE: begin
          if (ctl.alu_op) b_q <= alu_res;
        end
        default: ;
      endcase
    end
  end

  assign reg_a = a_q;
  assign reg_b = b_q;
  assign phase = ph;

  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> (phase == 2'd1 && reg_a == '0 && reg_b == '0));
  assert_a_only_decode_R11: assert property (@(posedge clk) disable iff (rst)
    (phase != 2'd2) |=> $stable(reg_a));
  assert_b_hold_decode_R4: assert property (@(posedge clk) disable iff (rst)
    (phase == 2'd2 && !ctl.clr) |=> $stable(reg_b));
  assert_clr_zero_R9: assert property (@(posedge clk) disable iff (rst)
    (phase == 2'd2 && ctl.clr) |=> (reg_a == '0 && reg_b == '0));
  assert_reserved_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (phase != 2'd1 && is_reserved) |=> ($stable(reg_a) && $stable(reg_b)));
endmodule

// File: tb/test_acc_core.sv
module test_acc_core;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] instr_in = 3'd0;
  logic [7:0] data_in = 8'd0;
  logic [7:0] reg_a, reg_b;
  logic [1:0] phase;

  int vectors = 0;
  int fails = 0;
  bit done = 0;

  int m_ph;
  int m_ir;
  int m_a;
  int m_b;
  string tag;

  always #5 clk = ~clk;

  acc_core i_acc_core (.clk(clk), .rst(rst), .instr_in(instr_in), .data_in(data_in),
                       .reg_a(reg_a), .reg_b(reg_b), .phase(phase));

  task automatic model_step();
    if (rst) begin
      m_ph = 1; m_ir = 0; m_a = 0; m_b = 0; tag = "R1";
      return;
    end
    case (m_ph)
      1: begin m_ir = instr_in; tag = "R2 R3 R11"; end
      2: begin
        if (m_ir == 4) begin m_a = 0; m_b = 0; tag = "R9"; end
        else if (m_ir < 4) begin m_a = data_in; tag = "R4"; end
        else tag = "R10";
      end
      default: begin
        case (m_ir)
          0: begin m_b = (m_b + m_a) % 256; tag = "R5"; end
          1: begin m_b = (m_b - m_a + 256) % 256; tag = "R6"; end
          2: begin m_b = m_b & m_a; tag = "R7"; end
          3: begin m_b = m_b | m_a; tag = "R8"; end
          4: tag = "R9";
          default: tag = "R10";
        endcase
      end
    endcase
    m_ph = (m_ph == 3) ? 1 : m_ph + 1;
  endtask

  task automatic cycle(input logic [2:0] ins, input logic [7:0] dat);
    instr_in = ins;
    data_in  = dat;
    model_step();
    @(negedge clk);
    vectors++;
    if (phase != m_ph[1:0] || reg_a != m_a[7:0] || reg_b != m_b[7:0]) begin
      fails++;
      $display("FAIL %s: phase/a/b = %0d/%0d/%0d expected %0d/%0d/%0d",
               tag, phase, reg_a, reg_b, m_ph, m_a, m_b);
    end
  endtask

  task automatic run_instr(input logic [2:0] op, input logic [7:0] dat);
    cycle(op, 8'($urandom));
    cycle(3'($urandom), dat);
    cycle(3'($urandom), 8'($urandom));
  endtask

  initial begin
    void'($urandom(7));
    @(negedge clk);
    cycle(3'd5, 8'hAA);
    cycle(3'd1, 8'h55);
    rst = 1'b0;
    // R5 wrap: 0+5, then 5+0xFB -> 0x00
    run_instr(3'b000, 8'h05);
    run_instr(3'b000, 8'hFB);
    // R6 borrow: 0-1 -> 0xFF
    run_instr(3'b001, 8'h01);
    // R7 and R8
    run_instr(3'b010, 8'h3C);
    run_instr(3'b011, 8'hC1);
    // R10 reserved codes with live data
    run_instr(3'b101, 8'h11);
    run_instr(3'b110, 8'h22);
    run_instr(3'b111, 8'h33);
    // R9 clear, then operate from zero
    run_instr(3'b100, 8'h77);
    run_instr(3'b001, 8'h80);
    // R1 mid-sequence reset
    cycle(3'd2, 8'h09);
    rst = 1'b1;
    cycle(3'd3, 8'h0F);
    rst = 1'b0;
    for (int k = 0; k < 600; k++) run_instr(3'($urandom), 8'($urandom));
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule